// File: doc/BRIEF.md
# Set-Bit Counter with Shared Datapath

This block returns the number of 1 bits in an input word. It does this one bit position per loop pass, using a small controller and one shared datapath. It is not a single-cycle population count. The datapath has a four-slot register file, a single ALU, a single shifter and a write selector. The write selector chooses between the input word and the shifter result. The controller has eight states. Each state sets the register-file read addresses, the ALU and shifter operations, the write slot and the output enable for one register transfer.

A request is made by raising `start` while the block is idle. The word on `in_word` is taken in the cycle that follows acceptance. The block then clears the count and sets a mask to one. It then repeats three transfers: AND the word with the mask, add the result to the count, and shift the word right. It stops after the shift that leaves the word at zero. In the final state the count is driven onto `res_data` with `res_en` high and `finished` is raised. `finished` stays high until the next request is accepted.

Top module: `bitcount_fsmd`

## Requirements
- R1: After synchronous reset, the block is idle, `finished` is 0, `res_en` is 0 and `res_data` is 0.
- R2: In idle, the block stays put for as long as `start` is 0. A `start` pulse that arrives while a count is running is ignored: it changes neither the result nor the timing.
- R3: The value on `res_data` while `res_en` is high equals the number of set bits in the accepted word. It never exceeds the word width W.
- R4: Call the cycle after the edge that accepts `start` cycle 1. The result state (with `res_en` high and `finished` high) is cycle 4+3n. Here n is the index of the highest set bit plus one, or 1 when the word is zero.
- R5: An all-zero word gives a count of 0, completes after a single loop pass, and raises `finished`.
- R6: `res_en` is high for exactly one cycle per request, namely the result state. In every other cycle `res_data` reads 0, which is the released-port value.
- R7: `finished` is 0 from cycle 1 of a request. It becomes 1 in the result state and holds at 1 until the next `start` is accepted.
- R8: `in_word` is sampled only in cycle 1. Changes to it in later cycles have no effect on the result.
- R9: A word with all W bits set gives the count W. The result state for this word is cycle 4+3W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; accepted only in idle |
| in_word | input | W | Word to count, sampled in cycle 1 of a request |
| finished | output | 1 | Completion flag, held until the next acceptance |
| res_en | output | 1 | Output port enable, high only in the result state |
| res_data | output | W | Count while `res_en` is high, otherwise 0 |

## Verification
Some behaviour is checked on every cycle by the assertions. These cover: idle holding while `start` is low, the exit from the loop on the zero status, the single-cycle result state followed by a return to idle, `finished` clearing on acceptance and holding afterwards, the enable appearing only together with `finished`, and the count staying within W. Other behaviour can only be shown by the bench scenarios, because it depends on the word being counted. These are the count value for each data pattern, the exact latency as a function of the highest set bit, the fact that `in_word` is ignored after cycle 1, and the fact that a `start` arriving mid-run is ignored.

// File: rtl/bc_pkg.sv
package bc_pkg;

  localparam int RF_DEPTH = 4;
  localparam int RF_AW    = $clog2(RF_DEPTH);

  // Fixed slot mapping of the loop variables
  localparam logic [RF_AW-1:0] SLOT_WORD = 2'd0;
  localparam logic [RF_AW-1:0] SLOT_MASK = 2'd1;
  localparam logic [RF_AW-1:0] SLOT_CNT  = 2'd2;
  localparam logic [RF_AW-1:0] SLOT_TMP  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_CLR   = 3'd2,
    ST_MASK  = 3'd3,
    ST_AND   = 3'd4,
    ST_ACC   = 3'd5,
    ST_SHIFT = 3'd6,
    ST_OUT   = 3'd7
  } bc_state_e;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_ADD  = 3'd1,
    OP_AND  = 3'd2,
    OP_INC  = 3'd3,
    OP_SUB  = 3'd4
  } bc_alu_op_e;

  typedef enum logic {
    SH_PASS  = 1'b0,
    SH_RIGHT = 1'b1
  } bc_sh_op_e;

  typedef struct packed {
    logic [RF_AW-1:0] rd_a;
    logic [RF_AW-1:0] rd_b;
    bc_alu_op_e       alu_op;
    bc_sh_op_e        sh_op;
    logic             wr_from_in;
    logic             wr_en;
    logic [RF_AW-1:0] wr_slot;
    logic             port_en;
  } bc_ctl_t;

endpackage

// File: rtl/bc_regfile.sv
module bc_regfile
  import bc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [RF_AW-1:0] wr_slot,
  input  logic [W-1:0]     wr_data,
  input  logic [RF_AW-1:0] rd_a_slot,
  input  logic [RF_AW-1:0] rd_b_slot,
  output logic [W-1:0]     rd_a,
  output logic [W-1:0]     rd_b
);

  logic [W-1:0] mem [RF_DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot] <= wr_data;
  end

  assign rd_a = mem[rd_a_slot];
  assign rd_b = mem[rd_b_slot];

endmodule

// File: rtl/bc_alu.sv
module bc_alu
  import bc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  bc_alu_op_e   op,
  output logic [W-1:0] y
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      OP_PASS: y = opa;
      OP_ADD:  y = opa + opb;
      OP_AND:  y = opa & opb;
      OP_INC:  y = opa + ONE;
      OP_SUB:  y = opa - opb;
      default: y = opa;
    endcase
  end

endmodule

// File: rtl/bc_shifter.sv
module bc_shifter
  import bc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  bc_sh_op_e    op,
  output logic [W-1:0] dout
);

  always_comb begin
    if (op == SH_RIGHT) dout = {1'b0, din[W-1:1]};
    else                dout = din;
  end

endmodule

// File: rtl/bc_ctrl.sv
module bc_ctrl
  import bc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      word_zero,
  output bc_state_e state,
  output bc_ctl_t   ctl,
  output logic      finished
);

  bc_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  nxt = start ? ST_LOAD : ST_IDLE;
      ST_LOAD:  nxt = ST_CLR;
      ST_CLR:   nxt = ST_MASK;
      ST_MASK:  nxt = ST_AND;
      ST_AND:   nxt = ST_ACC;
      ST_ACC:   nxt = ST_SHIFT;
      ST_SHIFT: nxt = word_zero ? ST_OUT : ST_AND;
      ST_OUT:   nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl            = '0;
    ctl.alu_op     = OP_PASS;
    ctl.sh_op      = SH_PASS;
    unique case (state)
      ST_LOAD: begin
        ctl.wr_en      = 1'b1;
        ctl.wr_from_in = 1'b1;
        ctl.wr_slot    = SLOT_WORD;
      end
      ST_CLR: begin
        ctl.rd_a    = SLOT_CNT;
        ctl.rd_b    = SLOT_CNT;
        ctl.alu_op  = OP_SUB;
        ctl.wr_en   = 1'b1;
        ctl.wr_slot = SLOT_CNT;
      end
      ST_MASK: begin
        ctl.rd_a    = SLOT_CNT;
        ctl.alu_op  = OP_INC;
        ctl.wr_en   = 1'b1;
        ctl.wr_slot = SLOT_MASK;
      end
      ST_AND: begin
        ctl.rd_a    = SLOT_WORD;
        ctl.rd_b    = SLOT_MASK;
        ctl.alu_op  = OP_AND;
        ctl.wr_en   = 1'b1;
        ctl.wr_slot = SLOT_TMP;
      end
      ST_ACC: begin
        ctl.rd_a    = SLOT_CNT;
        ctl.rd_b    = SLOT_TMP;
        ctl.alu_op  = OP_ADD;
        ctl.wr_en   = 1'b1;
        ctl.wr_slot = SLOT_CNT;
      end
      ST_SHIFT: begin
        ctl.rd_a    = SLOT_WORD;
        ctl.sh_op   = SH_RIGHT;
        ctl.wr_en   = 1'b1;
        ctl.wr_slot = SLOT_WORD;
      end
      ST_OUT: begin
        ctl.rd_a    = SLOT_CNT;
        ctl.port_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      finished <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && start)          finished <= 1'b0;
      else if (state == ST_SHIFT && word_zero) finished <= 1'b1;
    end
  end

  // R2: idle holds while no request is present
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> (state == ST_IDLE));

  // R2: a request during a run does not redirect the controller
  a_r2_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MASK && start) |=> (state == ST_AND));

  // R4: loop exits on zero status straight to the result state
  a_r4_loop_exit: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && word_zero) |=> (state == ST_OUT));

  // R6: result state lasts one cycle
  a_r6_single_out: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OUT) |=> (state == ST_IDLE));

  // R7: acceptance clears the completion flag
  a_r7_done_clear: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=> !finished);

  // R7: completion flag holds until acceptance
  a_r7_done_hold: assert property (@(posedge clk) disable iff (rst)
    (finished && !(state == ST_IDLE && start)) |=> finished);

endmodule

// File: rtl/bitcount_fsmd.sv
module bitcount_fsmd
  import bc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] in_word,
  output logic         finished,
  output logic         res_en,
  output logic [W-1:0] res_data
);

  bc_state_e    state;
  bc_ctl_t      ctl;
  logic [W-1:0] bus_a;
  logic [W-1:0] bus_b;
  logic [W-1:0] alu_y;
  logic [W-1:0] sh_y;
  logic [W-1:0] wr_data;
  logic         word_zero;

  bc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .word_zero (word_zero),
    .state     (state),
    .ctl       (ctl),
    .finished  (finished)
  );

  bc_regfile #(.W(W)) u_rf (
    .clk       (clk),
    .wr_en     (ctl.wr_en),
    .wr_slot   (ctl.wr_slot),
    .wr_data   (wr_data),
    .rd_a_slot (ctl.rd_a),
    .rd_b_slot (ctl.rd_b),
    .rd_a      (bus_a),
    .rd_b      (bus_b)
  );

  bc_alu #(.W(W)) u_alu (
    .opa (bus_a),
    .opb (bus_b),
    .op  (ctl.alu_op),
    .y   (alu_y)
  );

  bc_shifter #(.W(W)) u_sh (
    .din  (alu_y),
    .op   (ctl.sh_op),
    .dout (sh_y)
  );

  // Write selector and zero-detect status on the value being written back
  assign wr_data   = ctl.wr_from_in ? in_word : sh_y;
  assign word_zero = (sh_y == '0);

  assign res_en   = ctl.port_en;
  assign res_data = ctl.port_en ? bus_a : '0;

  // R6: port only drives while completion is flagged
  a_r6_port_with_done: assert property (@(posedge clk) disable iff (rst)
    res_en |-> finished);

  // R3: count never exceeds the word width
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
    res_en |-> (int'(res_data) <= W));

  // R6: enable drops right after the result cycle
  a_r6_enable_pulse: assert property (@(posedge clk) disable iff (rst)
    res_en |=> !res_en);

endmodule

// File: tb/tb_bitcount_fsmd.sv
`timescale 1ns/1ps
module tb_bitcount_fsmd;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [W-1:0] in_word;
  logic         finished;
  logic         res_en;
  logic [W-1:0] res_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bitcount_fsmd #(.W(W)) dut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_word  (in_word),
    .finished (finished),
    .res_en   (res_en),
    .res_data (res_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [W-1:0] w);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(w[i]);
    return c;
  endfunction

  function automatic int passes(input logic [W-1:0] w);
    int n = 1;
    for (int i = 0; i < W; i++) if (w[i]) n = i + 1;
    return n;
  endfunction

  task automatic reset_case();
    rst = 1'b1; start = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 finished", int'(finished), 0);
    check("R1 res_en", int'(res_en), 0);
    check("R1 res_data", int'(res_data), 0);
  endtask

  task automatic idle_case();
    int moved = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (finished || res_en) moved = 1;
    end
    check("R2 idle without start", moved, 0);
  endtask

  // Runs one request; poke_start raises start again mid-run
  task automatic run_case(input string req, input logic [W-1:0] w, input bit poke_start);
    int exp_c   = ones(w);
    int exp_lat = 4 + 3 * passes(w);
    int c       = 0;
    int early_en = 0;
    start   = 1'b1;
    in_word = w;
    do begin
      @(negedge clk);
      c++;
      if (c == 1) begin
        start = 1'b0;
        check({req, " R7 finished low in cycle 1"}, int'(finished), 0);
      end
      if (c == 2) in_word = ~w;          // R8: later changes ignored
      if (poke_start && c == 5) start = 1'b1;
      if (poke_start && c == 6) start = 1'b0;
      if (!finished && (res_en || res_data != '0)) early_en = 1;
    end while (!finished && c < 200);
    check({req, " R4 latency"}, c, exp_lat);
    check({req, " R3 count"}, int'(res_data), exp_c);
    check({req, " R6 enable in result cycle"}, int'(res_en), 1);
    check({req, " R6 port quiet before result"}, early_en, 0);
    @(negedge clk);
    check({req, " R6 enable dropped"}, int'(res_en), 0);
    check({req, " R6 port released"}, int'(res_data), 0);
    check({req, " R7 finished held"}, int'(finished), 1);
  endtask

  task automatic hold_case();
    int dropped = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!finished || res_en) dropped = 1;
    end
    check("R7 finished held in idle", dropped, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    reset_case();
    idle_case();
    run_case("R5 zero", 8'h00, 1'b0);
    run_case("R3 lsb", 8'h01, 1'b0);
    run_case("R4 msb", 8'h80, 1'b0);
    run_case("R9 all ones", 8'hFF, 1'b0);
    run_case("R3 mixed", 8'hA5, 1'b0);
    run_case("R8 middle", 8'h3C, 1'b0);
    run_case("R2 start mid-run", 8'h96, 1'b1);
    hold_case();
    run_case("R3 after hold", 8'h0B, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule